// File: doc/BRIEF.md
# Optical Bitstream Receiver with Symbol Detection

This block sits behind an optical front end that already produces sliced data bits, each marked by a one-cycle valid strobe. Every strobed bit enters a 32-bit shift register, most significant bit first, whose contents are always visible on a status output. Three comparators watch the window formed by the incoming bit. Two of them recognise boot start symbols: one asks for a chip-wide hard reset, the other starts program loading without a reset. The third recognises a frame delimiter for data sent after boot.

With the boot-mode input high, the block hunts for a start symbol. After the reset-requesting symbol it pulses a hard-reset request and ignores a configurable run of filler bits while that reset completes. After the other symbol it starts decoding at once. Program data arrives as 5-bit line codes. Each code becomes one nibble, and eight nibbles make a 32-bit word that is handed to the program loader with a one-cycle valid pulse. With the boot-mode input low, the block delivers the raw stream instead. It pulses a word interrupt for every 32 received bits and a separate one-cycle interrupt whenever the register holds the delimiter. The delimiter also realigns the word count.

Top module: `optrx_core`

## Requirements
- R1: Each `bit_vld_i` strobe shifts `bit_i` into bit 0 of the register and moves the older bits up by one. The new value shows on `shreg_o` in the cycle after the strobe. Without a strobe, `shreg_o` holds. The register resets to zero and all pulse outputs reset low.
- R2: In boot mode, while hunting, a register value of 32'hA9B0A732 (bytes 169, 176, 167, 50, the first byte in bits 31:24) raises `hard_reset_o` for exactly one cycle after the completing strobe. The next FILL_BITS strobes (default 64) are ignored, and decoding starts with the bit after them.
- R3: In boot mode, while hunting, a register value of 32'hB8545928 (bytes 184, 84, 89, 40) starts decoding with the very next bit. No reset request and no filler follow.
- R4: While decoding, every five bits form one code, with the first bit as the code's MSB. Codes 11110,01001,10100,10101,01010,01011,01110,01111,10010,10011,10110,10111,11010,11011,11100,11101 decode to nibbles 0 through F in that order.
- R5: Eight decoded nibbles form one word, with the first nibble in bits 31:28. `load_word_o` carries the word while `load_vld_o` is high for one cycle after the strobe that completed the eighth code.
- R6: Any other 5-bit code sets `code_err_o`, which stays high until reset. The nibble is dropped, so the word is completed by the next valid codes.
- R7: In data mode, `word_irq_o` pulses for one cycle on every 32nd strobe. Counting starts when boot mode is left.
- R8: In data mode, a register value of 32'hDDB0E72F (bytes 221, 176, 231, 47) pulses `delim_irq_o` for one cycle and restarts the word count, so the next `word_irq_o` follows exactly 32 strobes later.
- R9: In data mode the two start symbols are ignored (no `hard_reset_o`, no loader words). Neither interrupt pulses in boot mode.
- R10: Lowering `boot_mode_i` abandons any filler or decoding in progress. After boot mode is entered again, no words are loaded until a new start symbol arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Sliced data bit |
| bit_vld_i | input | 1 | One-cycle strobe marking `bit_i` valid |
| boot_mode_i | input | 1 | 1: hunt symbols and load program; 0: raw data delivery |
| hard_reset_o | output | 1 | One-cycle hard-reset request |
| load_word_o | output | 32 | Decoded program word |
| load_vld_o | output | 1 | One-cycle valid for `load_word_o` |
| code_err_o | output | 1 | Sticky invalid-code flag |
| word_irq_o | output | 1 | One-cycle pulse every 32 data bits |
| delim_irq_o | output | 1 | One-cycle pulse on delimiter match |
| shreg_o | output | 32 | Current shift-register contents |

## Verification
A shift register that slips by one bit shows on `shreg_o` in the cycle after the strobe. It also hides every symbol, so a missing reset pulse or delimiter interrupt gives it away within one 32-bit pattern. A stuck hunt, filler or decode state only appears at `load_vld_o`. That takes a full word of eight codes after the symbol, so each loaded word is compared to its expected value. A word count that is off by one shows on `word_irq_o` within 32 strobes of entering data mode or of a delimiter.

// File: rtl/optrx_pkg.sv
package optrx_pkg;
    localparam int SR_W = 32;
    localparam int NPAT = 3;
    localparam int P_RST = 0;
    localparam int P_SKIP = 1;
    localparam int P_DELIM = 2;
    localparam logic [SR_W-1:0] PATTERNS [NPAT] = '{
        32'hA9B0A732,
        32'hB8545928,
        32'hDDB0E72F
    };

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_FILL = 2'd1,
        ST_LOAD = 2'd2
    } boot_st_e;
endpackage

// File: rtl/optrx_match.sv
module optrx_match #(
    parameter int W = 32,
    parameter logic [W-1:0] PAT = '0
) (
    input  logic [W-1:0] win_i,
    output logic         hit_o
);
    assign hit_o = (win_i == PAT);
endmodule

// File: rtl/optrx_dec5b4b.sv
module optrx_dec5b4b (
    input  logic [4:0] code_i,
    output logic [3:0] nib_o,
    output logic       ok_o
);
    always_comb begin
        ok_o  = 1'b1;
        nib_o = 4'h0;
        case (code_i)
            5'b11110: nib_o = 4'h0;
            5'b01001: nib_o = 4'h1;
            5'b10100: nib_o = 4'h2;
            5'b10101: nib_o = 4'h3;
            5'b01010: nib_o = 4'h4;
            5'b01011: nib_o = 4'h5;
            5'b01110: nib_o = 4'h6;
            5'b01111: nib_o = 4'h7;
            5'b10010: nib_o = 4'h8;
            5'b10011: nib_o = 4'h9;
            5'b10110: nib_o = 4'hA;
            5'b10111: nib_o = 4'hB;
            5'b11010: nib_o = 4'hC;
            5'b11011: nib_o = 4'hD;
            5'b11100: nib_o = 4'hE;
            5'b11101: nib_o = 4'hF;
            default:  ok_o  = 1'b0;
        endcase
    end
endmodule

// File: rtl/optrx_core.sv
module optrx_core
    import optrx_pkg::*;
#(
    parameter int FILL_BITS = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_i,
    input  logic            bit_vld_i,
    input  logic            boot_mode_i,
    output logic            hard_reset_o,
    output logic [SR_W-1:0] load_word_o,
    output logic            load_vld_o,
    output logic            code_err_o,
    output logic            word_irq_o,
    output logic            delim_irq_o,
    output logic [SR_W-1:0] shreg_o
);
    localparam int NIB_N = SR_W / 4;
    localparam int FCW   = $clog2(FILL_BITS + 1);
    localparam int NCW   = $clog2(NIB_N);
    localparam int BCW   = $clog2(SR_W);

    typedef struct packed {
        boot_st_e        st;
        logic [SR_W-1:0] sr;
        logic [FCW-1:0]  fill_cnt;
        logic [3:0]      code;
        logic [2:0]      code_cnt;
        logic [SR_W-1:0] acc;
        logic [NCW-1:0]  nib_cnt;
        logic [SR_W-1:0] word;
        logic            word_vld;
        logic            hrst;
        logic            err;
        logic [BCW-1:0]  bit_cnt;
        logic            wirq;
        logic            dirq;
    } state_t;

    state_t q, d;

    logic [SR_W-1:0] sr_nxt;
    logic [4:0]      code_nxt;
    logic [NPAT-1:0] hit;
    logic [3:0]      nib;
    logic            nib_ok;
    logic [SR_W-1:0] acc_nxt;

    assign sr_nxt   = {q.sr[SR_W-2:0], bit_i};
    assign code_nxt = {q.code, bit_i};
    assign acc_nxt  = {q.acc[SR_W-5:0], nib};

    for (genvar gi = 0; gi < NPAT; gi++) begin : g_match
        optrx_match #(.W(SR_W), .PAT(PATTERNS[gi])) match_i (
            .win_i (sr_nxt),
            .hit_o (hit[gi])
        );
    end

    optrx_dec5b4b dec_i (
        .code_i (code_nxt),
        .nib_o  (nib),
        .ok_o   (nib_ok)
    );

    always_comb begin
        d          = q;
        d.word_vld = 1'b0;
        d.hrst     = 1'b0;
        d.wirq     = 1'b0;
        d.dirq     = 1'b0;
        if (!boot_mode_i) begin
            d.st       = ST_HUNT;
            d.fill_cnt = '0;
            d.code_cnt = '0;
            d.nib_cnt  = '0;
        end else begin
            d.bit_cnt = '0;
        end
        if (bit_vld_i) begin
            d.sr = sr_nxt;
            if (boot_mode_i) begin
                case (q.st)
                    ST_HUNT: begin
                        if (hit[P_RST]) begin
                            d.hrst     = 1'b1;
                            d.st       = ST_FILL;
                            d.fill_cnt = '0;
                        end else if (hit[P_SKIP]) begin
                            d.st       = ST_LOAD;
                            d.code_cnt = '0;
                            d.nib_cnt  = '0;
                        end
                    end
                    ST_FILL: begin
                        if (q.fill_cnt == FCW'(FILL_BITS - 1)) begin
                            d.st       = ST_LOAD;
                            d.code_cnt = '0;
                            d.nib_cnt  = '0;
                        end else begin
                            d.fill_cnt = q.fill_cnt + 1'b1;
                        end
                    end
                    ST_LOAD: begin
                        if (q.code_cnt == 3'd4) begin
                            d.code_cnt = '0;
                            if (nib_ok) begin
                                d.acc = acc_nxt;
                                if (q.nib_cnt == NCW'(NIB_N - 1)) begin
                                    d.word     = acc_nxt;
                                    d.word_vld = 1'b1;
                                    d.nib_cnt  = '0;
                                end else begin
                                    d.nib_cnt = q.nib_cnt + 1'b1;
                                end
                            end else begin
                                d.err = 1'b1;
                            end
                        end else begin
                            d.code     = code_nxt[3:0];
                            d.code_cnt = q.code_cnt + 1'b1;
                        end
                    end
                    default: d.st = ST_HUNT;
                endcase
            end else begin
                if (hit[P_DELIM]) begin
                    d.dirq    = 1'b1;
                    d.bit_cnt = '0;
                end else if (q.bit_cnt == BCW'(SR_W - 1)) begin
                    d.wirq    = 1'b1;
                    d.bit_cnt = '0;
                end else begin
                    d.bit_cnt = q.bit_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_HUNT, default: '0};
        end else begin
            q <= d;
        end
    end

    assign hard_reset_o = q.hrst;
    assign load_word_o  = q.word;
    assign load_vld_o   = q.word_vld;
    assign code_err_o   = q.err;
    assign word_irq_o   = q.wirq;
    assign delim_irq_o  = q.dirq;
    assign shreg_o      = q.sr;
endmodule

// File: rtl/optrx_core_chk.sv
module optrx_core_chk
    import optrx_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            bit_i,
    input logic            bit_vld_i,
    input logic            boot_mode_i,
    input logic            hard_reset_o,
    input logic            load_vld_o,
    input logic            code_err_o,
    input logic            word_irq_o,
    input logic            delim_irq_o,
    input logic [SR_W-1:0] shreg_o
);
    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_i |=> shreg_o == {$past(shreg_o[SR_W-2:0]), $past(bit_i)}); // R1
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld_i |=> $stable(shreg_o)); // R1
    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hard_reset_o |=> !hard_reset_o); // R2
    AST_RST_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        hard_reset_o |-> shreg_o == PATTERNS[P_RST]); // R2
    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_vld_o |=> !load_vld_o); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        code_err_o |=> code_err_o); // R6
    AST_DELIM_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        delim_irq_o |-> shreg_o == PATTERNS[P_DELIM]); // R8
    AST_IRQ_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (word_irq_o || delim_irq_o) |-> $past(!boot_mode_i && bit_vld_i)); // R9
    AST_LOAD_BOOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_vld_o || hard_reset_o) |-> $past(boot_mode_i)); // R9
endmodule

bind optrx_core optrx_core_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_i        (bit_i),
    .bit_vld_i    (bit_vld_i),
    .boot_mode_i  (boot_mode_i),
    .hard_reset_o (hard_reset_o),
    .load_vld_o   (load_vld_o),
    .code_err_o   (code_err_o),
    .word_irq_o   (word_irq_o),
    .delim_irq_o  (delim_irq_o),
    .shreg_o      (shreg_o)
);

// File: tb/optrx_core_tb_top.sv
module optrx_core_tb_top;
    localparam int FILL = 64;
    localparam logic [4:0] ENC [16] = '{
        5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
        5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101
    };
    typedef struct packed {
        logic [31:0] stim;
        logic [31:0] expd;
    } vec_t;
    localparam vec_t VECS [4] = '{
        '{32'h01234567, 32'h01234567},
        '{32'h89ABCDEF, 32'h89ABCDEF},
        '{32'hFEDCBA98, 32'hFEDCBA98},
        '{32'h5A5A0F0F, 32'h5A5A0F0F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_i = 1'b0;
    logic        bit_vld_i = 1'b0;
    logic        boot_mode_i = 1'b0;
    logic        hard_reset_o, load_vld_o, code_err_o, word_irq_o, delim_irq_o;
    logic [31:0] load_word_o, shreg_o;

    int n_checks = 0;
    int n_fail = 0;
    int hrst_cnt = 0, load_cnt = 0, wirq_cnt = 0, dirq_cnt = 0;
    logic [31:0] last_word = '0;

    always #2.5 clk = ~clk;

    optrx_core #(.FILL_BITS(FILL)) dut_i (
        .clk (clk), .rst_n (rst_n), .bit_i (bit_i), .bit_vld_i (bit_vld_i),
        .boot_mode_i (boot_mode_i), .hard_reset_o (hard_reset_o),
        .load_word_o (load_word_o), .load_vld_o (load_vld_o),
        .code_err_o (code_err_o), .word_irq_o (word_irq_o),
        .delim_irq_o (delim_irq_o), .shreg_o (shreg_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            hrst_cnt <= hrst_cnt + int'(hard_reset_o);
            load_cnt <= load_cnt + int'(load_vld_o);
            wirq_cnt <= wirq_cnt + int'(word_irq_o);
            dirq_cnt <= dirq_cnt + int'(delim_irq_o);
            if (load_vld_o) last_word <= load_word_o;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_i = b;
        bit_vld_i = 1'b1;
        @(negedge clk);
        bit_vld_i = 1'b0;
        #1;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_code(input logic [4:0] c);
        for (int i = 4; i >= 0; i--) send_bit(c[i]);
    endtask

    task automatic send_enc_word(input logic [31:0] w);
        for (int i = 7; i >= 0; i--) send_code(ENC[w[i*4 +: 4]]);
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int w0, l0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(shreg_o == 32'h0 && !hard_reset_o && !load_vld_o && !code_err_o
              && !word_irq_o && !delim_irq_o, "R1 reset", shreg_o, 32'h0);

        // R1, R7: data mode shifting and word interrupt
        send_bits(32'h12345678, 31);
        check(wirq_cnt == 0, "R7 no irq before 32 bits", wirq_cnt, 0);
        send_bits(32'h0, 1);
        check(shreg_o == 32'h2468ACF0, "R1 msb first shift", shreg_o, 32'h2468ACF0);
        check(wirq_cnt == 1, "R7 irq at 32 bits", wirq_cnt, 1);
        repeat (4) @(negedge clk);
        #1;
        check(shreg_o == 32'h2468ACF0, "R1 hold without strobe", shreg_o, 32'h2468ACF0);

        // R9: boot symbols ignored in data mode
        send_bits(32'hA9B0A732, 32);
        send_bits(32'hB8545928, 32);
        check(hrst_cnt == 0 && load_cnt == 0, "R9 start symbols ignored", hrst_cnt, 0);

        // R8: delimiter interrupt and count restart
        send_bits(32'h0, 8);
        send_bits(32'hDDB0E72F, 32);
        check(dirq_cnt == 1, "R8 delimiter pulse", dirq_cnt, 1);
        w0 = wirq_cnt;
        send_bits(32'h0, 31);
        check(wirq_cnt == w0, "R8 no irq before realigned 32", wirq_cnt, w0);
        send_bits(32'h0, 1);
        check(wirq_cnt == w0 + 1, "R8 irq 32 bits after delimiter", wirq_cnt, w0 + 1);

        // R3, R4, R5: skip symbol and table-driven word loading
        @(negedge clk);
        boot_mode_i = 1'b1;
        send_bits(32'hB8545928, 32);
        check(hrst_cnt == 0, "R3 no reset request on skip symbol", hrst_cnt, 0);
        w0 = wirq_cnt;
        for (int v = 0; v < 4; v++) begin
            l0 = load_cnt;
            send_enc_word(VECS[v].stim);
            check(load_cnt == l0 + 1 && last_word == VECS[v].expd, "R4 R5 decoded word",
                  last_word, VECS[v].expd);
        end
        check(wirq_cnt == w0 && dirq_cnt == 1, "R9 no irq in boot mode", wirq_cnt, w0);

        // R6: invalid code sets sticky error, nibble dropped
        check(!code_err_o, "R6 error clear before bad code", 32'(code_err_o), 0);
        l0 = load_cnt;
        send_code(5'b00000);
        check(code_err_o, "R6 error set", 32'(code_err_o), 1);
        send_enc_word(32'hC0FFEE11);
        check(load_cnt == l0 + 1 && last_word == 32'hC0FFEE11, "R6 bad nibble dropped",
              last_word, 32'hC0FFEE11);

        // R10: leaving boot mode forces a new symbol hunt
        @(negedge clk);
        boot_mode_i = 1'b0;
        repeat (2) @(negedge clk);
        boot_mode_i = 1'b1;
        l0 = load_cnt;
        send_enc_word(32'h13579BDF);
        check(load_cnt == l0, "R10 no load without start symbol", load_cnt, l0);

        // R2: reset symbol, one-cycle pulse, filler skipped
        send_bits(32'hA9B0A732, 32);
        check(hrst_cnt == 1, "R2 one-cycle reset request", hrst_cnt, 1);
        send_bits(32'hFFFFFFFF, 32);
        send_bits(32'hFFFFFFFF, FILL - 32);
        check(load_cnt == l0, "R2 filler ignored", load_cnt, l0);
        send_enc_word(32'h2468ACE0);
        check(load_cnt == l0 + 1 && last_word == 32'h2468ACE0, "R2 load after filler",
              last_word, 32'h2468ACE0);
        check(code_err_o, "R6 error still sticky", 32'(code_err_o), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule